// File: doc/BRIEF.md
# Interrupt Source Presentation Table

This block keeps a small table of interrupt sources and decides when each one is offered to an interrupt presenter. Every entry holds a two-bit pending/queued state, a priority, a flag that marks the source as level-type or message-type, a retry flag, and a flag that records an occurrence that arrived while the source was masked. Events arrive one per cycle on a valid/ready port. Each event carries a kind code and a source index. The kinds are trigger, end-of-interrupt, presenter rejection, retry scan, configuration and level drop. When an event calls for delivery, the block raises a single offer carrying the source index and its priority. It then waits for the presenter to answer with either accepted or failed.

Repeated message triggers collapse into at most one queued occurrence behind the one in service. A masked source never reaches the presenter, and it does not lose the occurrence either: when it is unmasked, it is offered. A failed offer leaves the source marked for retry, and a later scan re-offers the marked sources in ascending index order. Events that name an index outside the table change nothing and are counted.

Top module: `isrc_table`

## Requirements
- R1: After reset `ev_ready` is 1, `off_valid` is 0, `err_count` is 0, and every entry has the masked priority (all ones), so a trigger before any configuration produces no offer.
- R2: A trigger (kind 0) on a message source (level flag 0) replaces the state {Q,P} (P in bit 0, Q in bit 1) with {old P, 1}. An offer is made only when the result is P=1, Q=0.
- R3: An end-of-interrupt (kind 1) on a message source moves Q into P and clears Q. If P is then 1, the source is offered again.
- R4: On a level source (level flag 1), a trigger (kind 0) sets P and offers only if P was 0. An end-of-interrupt (kind 1) leaves the state unchanged and offers again if P is 1. A level drop (kind 5) clears P and Q on any entry.
- R5: Whenever an offer is due and the entry's priority is all ones, no offer is made and the masked-pending flag is set instead. This applies to retries as well. A configuration event (kind 3'd4, carrying priority and level flag) that gives a masked-pending entry a non-masked priority offers it once at the new priority and clears the flag.
- R6: A response with `rsp_ok`=0 sets the retry flag of the offered source. A retry scan (kind 3, source index ignored) visits all entries in ascending index order. Each flagged entry has its flag cleared and is offered. Unflagged entries are not offered, and a second scan offers nothing.
- R7: A rejection (kind 2) offers the source at once at its priority, whatever its pending state, and leaves that state unchanged.
- R8: At most one offer is outstanding. While `off_valid` is 1, `ev_ready` is 0 and the offer's index and priority hold steady until the cycle `rsp_valid` is 1. After that cycle `off_valid` is 0.
- R9: An event other than a retry scan whose index is not below the table size changes no entry, makes no offer, and increments `err_count`. The counter saturates at its all-ones value by default.
- R10: An offer appears on the clock edge after the event that causes it. It carries that entry's index in `off_src` and its priority in `off_prio`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Block can take an event |
| ev_kind | input | 3 | 0 trigger, 1 end-of-interrupt, 2 rejection, 3 retry scan, 4 configuration, 5 level drop |
| ev_src | input | SRC_W (5) | Source index |
| ev_prio | input | PRIO_W (8) | Priority for configuration events |
| ev_lsi | input | 1 | Level-type flag for configuration events |
| off_valid | output | 1 | Delivery offer outstanding |
| off_src | output | SRC_W (5) | Index of the offered source |
| off_prio | output | PRIO_W (8) | Priority of the offered source |
| rsp_valid | input | 1 | Presenter answers the offer |
| rsp_ok | input | 1 | 1 accepted, 0 failed |
| err_count | output | ERR_W (4) | Count of out-of-range events |

## Verification
The hardest situation to reach is a retry scan that finds flagged entries, some masked and some not, while the pending states sit in every combination of P and Q. A sweep over all sixteen entries interleaves triggers and end-of-interrupts in a pattern that passes through each of the four states, and it fails a fixed fraction of the offers so that retry flags pile up across the table. One entry is then masked after a failed offer, and the scan must skip it, park it as masked-pending and offer it on unmask. The bench tracks every entry arithmetically, and because the expected offer order comes straight from the retry flags, each scan is checked entry by entry.

// File: rtl/isrc_pkg.sv
package isrc_pkg;

   typedef enum logic [2:0] {
      EV_TRIG   = 3'd0,
      EV_EOI    = 3'd1,
      EV_REJECT = 3'd2,
      EV_RESCAN = 3'd3,
      EV_CONFIG = 3'd4,
      EV_LOWER  = 3'd5
   } ev_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAIT,
      ST_SCAN
   } isrc_state_e;

   localparam logic [1:0] PQ_P = 2'b01;

endpackage

// File: rtl/isrc_pq_step.sv
module isrc_pq_step
   import isrc_pkg::*;
(
   input  logic [2:0] kind,
   input  logic       lsi,
   input  logic [1:0] pq_cur,
   output logic [1:0] pq_nx,
   output logic       want
);

   always_comb begin
      pq_nx = pq_cur;
      want  = 1'b0;
      case (kind)
         EV_TRIG: begin
            if (lsi) begin
               pq_nx = pq_cur | PQ_P;
               want  = !pq_cur[0];
            end else begin
               pq_nx = {pq_cur[0], 1'b1};
               want  = (pq_nx == PQ_P);
            end
         end
         EV_EOI: begin
            if (!lsi) pq_nx = {1'b0, pq_cur[1]};
            want = pq_nx[0];
         end
         EV_REJECT: want = 1'b1;
         EV_LOWER:  pq_nx = 2'b00;
         default: ;
      endcase
   end

endmodule

// File: rtl/isrc_errcnt.sv
module isrc_errcnt #(
   parameter int W   = 4,
   parameter bit SAT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   logic [W-1:0] nxt;

   generate
      if (SAT) begin : g_sat
         assign nxt = (count == TOP) ? count : count + 1'b1;
      end else begin : g_wrap
         assign nxt = count + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= nxt;
   end

endmodule

// File: rtl/isrc_table.sv
module isrc_table
   import isrc_pkg::*;
#(
   parameter int NUM_SRC = 16,
   parameter int SRC_W   = 5,
   parameter int PRIO_W  = 8,
   parameter int ERR_W   = 4,
   parameter bit ERR_SAT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_valid,
   output logic              ev_ready,
   input  logic [2:0]        ev_kind,
   input  logic [SRC_W-1:0]  ev_src,
   input  logic [PRIO_W-1:0] ev_prio,
   input  logic              ev_lsi,
   output logic              off_valid,
   output logic [SRC_W-1:0]  off_src,
   output logic [PRIO_W-1:0] off_prio,
   input  logic              rsp_valid,
   input  logic              rsp_ok,
   output logic [ERR_W-1:0]  err_count
);

   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam logic [PRIO_W-1:0] MASKED = {PRIO_W{1'b1}};
   localparam logic [IDX_W-1:0]  LAST   = IDX_W'(NUM_SRC - 1);

   generate
      if (NUM_SRC < 2 || NUM_SRC > (1 << SRC_W) || IDX_W > SRC_W) begin : g_bad_size
         $error("isrc_table: NUM_SRC does not fit SRC_W");
      end
      if (PRIO_W < 2 || ERR_W < 1) begin : g_bad_width
         $error("isrc_table: PRIO_W or ERR_W too small");
      end
   endgenerate

   // entry storage
   logic [1:0]         pq_q   [NUM_SRC];
   logic [PRIO_W-1:0]  prio_q [NUM_SRC];
   logic [NUM_SRC-1:0] lsi_q, rs_q, mp_q;

   isrc_state_e        state;
   logic               ret_scan;
   logic [IDX_W-1:0]   ptr;
   logic               ov_q;
   logic [IDX_W-1:0]   ov_idx;
   logic [PRIO_W-1:0]  ov_prio;

   // event decode
   logic              accept, in_range, want, cfg_unmask, cur_masked, cnt_inc;
   logic [IDX_W-1:0]  idx;
   logic [1:0]        pq_nx;

   assign ev_ready  = (state == ST_IDLE);
   assign accept    = ev_valid && ev_ready;
   assign in_range  = (32'(ev_src) < NUM_SRC);
   assign idx       = ev_src[IDX_W-1:0];
   assign cur_masked = (prio_q[idx] == MASKED);
   assign cfg_unmask = (ev_kind == EV_CONFIG) && mp_q[idx] && (ev_prio != MASKED);
   assign cnt_inc   = accept && !in_range && (ev_kind != EV_RESCAN);

   isrc_pq_step u_step (
      .kind   (ev_kind),
      .lsi    (lsi_q[idx]),
      .pq_cur (pq_q[idx]),
      .pq_nx  (pq_nx),
      .want   (want)
   );

   isrc_errcnt #(.W(ERR_W), .SAT(ERR_SAT)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc),
      .count (err_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ret_scan <= 1'b0;
         ptr      <= '0;
         ov_q     <= 1'b0;
         ov_idx   <= '0;
         ov_prio  <= '0;
         lsi_q    <= '0;
         rs_q     <= '0;
         mp_q     <= '0;
         for (int i = 0; i < NUM_SRC; i++) begin
            pq_q[i]   <= 2'b00;
            prio_q[i] <= MASKED;
         end
      end else begin
         case (state)
            ST_IDLE: begin
               if (accept && ev_kind == EV_RESCAN) begin
                  ptr   <= '0;
                  state <= ST_SCAN;
               end else if (accept && in_range) begin
                  pq_q[idx] <= pq_nx;
                  if (ev_kind == EV_CONFIG) begin
                     prio_q[idx] <= ev_prio;
                     lsi_q[idx]  <= ev_lsi;
                  end
                  if (cfg_unmask) begin
                     mp_q[idx] <= 1'b0;
                     ov_q      <= 1'b1;
                     ov_idx    <= idx;
                     ov_prio   <= ev_prio;
                     ret_scan  <= 1'b0;
                     state     <= ST_WAIT;
                  end else if (want && cur_masked) begin
                     mp_q[idx] <= 1'b1;
                  end else if (want) begin
                     ov_q     <= 1'b1;
                     ov_idx   <= idx;
                     ov_prio  <= prio_q[idx];
                     ret_scan <= 1'b0;
                     state    <= ST_WAIT;
                  end
               end
            end
            ST_SCAN: begin
               ptr <= ptr + 1'b1;
               if (rs_q[ptr]) begin
                  rs_q[ptr] <= 1'b0;
                  if (prio_q[ptr] == MASKED) begin
                     mp_q[ptr] <= 1'b1;
                     if (ptr == LAST) state <= ST_IDLE;
                  end else begin
                     ov_q     <= 1'b1;
                     ov_idx   <= ptr;
                     ov_prio  <= prio_q[ptr];
                     ret_scan <= (ptr != LAST);
                     state    <= ST_WAIT;
                  end
               end else if (ptr == LAST) begin
                  state <= ST_IDLE;
               end
            end
            ST_WAIT: begin
               if (rsp_valid) begin
                  ov_q <= 1'b0;
                  if (!rsp_ok) rs_q[ov_idx] <= 1'b1;
                  state <= ret_scan ? ST_SCAN : ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign off_valid = ov_q;
   assign off_src   = SRC_W'(ov_idx);
   assign off_prio  = ov_prio;

endmodule

// File: rtl/isrc_table_chk.sv
module isrc_table_chk #(
   parameter int NUM_SRC = 16,
   parameter int SRC_W   = 5,
   parameter int PRIO_W  = 8,
   parameter int ERR_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_valid,
   input logic              ev_ready,
   input logic [2:0]        ev_kind,
   input logic [SRC_W-1:0]  ev_src,
   input logic              off_valid,
   input logic [SRC_W-1:0]  off_src,
   input logic [PRIO_W-1:0] off_prio,
   input logic              rsp_valid,
   input logic [ERR_W-1:0]  err_count
);

   localparam logic [PRIO_W-1:0] MASKED = {PRIO_W{1'b1}};

   logic oob_ev;
   assign oob_ev = ev_valid && ev_ready && (32'(ev_src) >= NUM_SRC) && (ev_kind != 3'd3);

   p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
      off_valid |-> !ev_ready);

   p_hold_offer_r8: assert property (@(posedge clk) disable iff (!rst_n)
      off_valid && !rsp_valid |=> off_valid && $stable(off_src) && $stable(off_prio));

   p_rsp_retires_r8: assert property (@(posedge clk) disable iff (!rst_n)
      off_valid && rsp_valid |=> !off_valid);

   p_no_masked_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
      off_valid |-> off_prio != MASKED);

   p_offer_in_table_r10: assert property (@(posedge clk) disable iff (!rst_n)
      off_valid |-> 32'(off_src) < NUM_SRC);

   p_oob_no_offer_r9: assert property (@(posedge clk) disable iff (!rst_n)
      oob_ev |=> !off_valid);

   p_err_only_oob_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !oob_ev |=> $stable(err_count));

endmodule

bind isrc_table isrc_table_chk #(
   .NUM_SRC (NUM_SRC),
   .SRC_W   (SRC_W),
   .PRIO_W  (PRIO_W),
   .ERR_W   (ERR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ev_valid  (ev_valid),
   .ev_ready  (ev_ready),
   .ev_kind   (ev_kind),
   .ev_src    (ev_src),
   .off_valid (off_valid),
   .off_src   (off_src),
   .off_prio  (off_prio),
   .rsp_valid (rsp_valid),
   .err_count (err_count)
);

// File: tb/test_isrc_table.sv
module test_isrc_table;

   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 16;
   localparam int ERR_MAX = 15;

   logic       clk, rst_n;
   logic       ev_valid, ev_ready, ev_lsi;
   logic [2:0] ev_kind;
   logic [4:0] ev_src;
   logic [7:0] ev_prio;
   logic       off_valid;
   logic [4:0] off_src;
   logic [7:0] off_prio;
   logic       rsp_valid, rsp_ok;
   logic [3:0] err_count;

   isrc_table i_isrc_table (
      .clk(clk), .rst_n(rst_n),
      .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind),
      .ev_src(ev_src), .ev_prio(ev_prio), .ev_lsi(ev_lsi),
      .off_valid(off_valid), .off_src(off_src), .off_prio(off_prio),
      .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .err_count(err_count)
   );

   int n_chk = 0;
   int n_fail = 0;

   int pq_m [NSRC];
   int prio_m [NSRC];
   bit lsi_m [NSRC];
   bit mp_m [NSRC];
   bit rs_m [NSRC];
   int err_m = 0;

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send(input int kind, input int src, input int prio, input bit lsi);
      @(negedge clk);
      while (!ev_ready) @(negedge clk);
      ev_valid = 1'b1;
      ev_kind  = 3'(kind);
      ev_src   = 5'(src);
      ev_prio  = 8'(prio);
      ev_lsi   = lsi;
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   task automatic respond(input bit ok);
      rsp_valid = 1'b1;
      rsp_ok    = ok;
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   // one event, expected result from the per-entry arithmetic model
   task automatic op(input int kind, input int src, input int prio, input bit lsi,
                     input bit ok, input int hold, input string req);
      bit exp_off = 0;
      bit w = 0;
      int exp_prio = 0;
      int n;
      if (src >= NSRC) begin
         if (err_m < ERR_MAX) err_m++;
      end else begin
         case (kind)
            0: begin
               n = lsi_m[src] ? (pq_m[src] | 1) : (((pq_m[src] << 1) & 3) | 1);
               w = lsi_m[src] ? ((pq_m[src] & 1) == 0) : (n == 1);
               pq_m[src] = n;
            end
            1: begin
               n = lsi_m[src] ? pq_m[src] : (pq_m[src] >> 1);
               w = (n & 1) == 1;
               pq_m[src] = n;
            end
            2: w = 1;
            4: begin
               if (mp_m[src] && prio != 255) begin
                  exp_off = 1; exp_prio = prio; mp_m[src] = 0;
               end
               prio_m[src] = prio;
               lsi_m[src] = lsi;
            end
            5: pq_m[src] = 0;
            default: ;
         endcase
         if (w) begin
            if (prio_m[src] == 255) mp_m[src] = 1;
            else begin exp_off = 1; exp_prio = prio_m[src]; end
         end
      end
      send(kind, src, prio, lsi);
      chk(off_valid == exp_off, {req, " offer"}, int'(off_valid), int'(exp_off));
      chk(int'(err_count) == err_m, {req, " err_count"}, int'(err_count), err_m);
      if (exp_off && off_valid) begin
         chk(int'(off_src) == src, {req, " R10 index"}, int'(off_src), src);
         chk(int'(off_prio) == exp_prio, {req, " R10 prio"}, int'(off_prio), exp_prio);
         for (int k = 0; k < hold; k++) begin
            ev_valid = 1'b1; ev_kind = 3'd0; ev_src = 5'd0;
            @(negedge clk);
            chk(ev_ready == 1'b0, "R8 ready low while pending", int'(ev_ready), 0);
            chk(off_valid && int'(off_src) == src && int'(off_prio) == exp_prio,
                "R8 offer held", int'(off_src), src);
            ev_valid = 1'b0;
         end
         respond(ok);
         chk(off_valid == 1'b0, "R8 offer retired", int'(off_valid), 0);
         if (!ok) rs_m[src] = 1;
      end
   endtask

   task automatic wait_offer(input int src, input int prio, input string req);
      for (int k = 0; k < 64 && !off_valid; k++) @(negedge clk);
      chk(off_valid == 1'b1, {req, " scan offer"}, int'(off_valid), 1);
      chk(int'(off_src) == src, {req, " scan index"}, int'(off_src), src);
      chk(int'(off_prio) == prio, {req, " scan prio"}, int'(off_prio), prio);
   endtask

   task automatic rescan(input string req);
      bit stray = 0;
      send(3, 0, 0, 0);
      for (int i = 0; i < NSRC; i++) begin
         if (rs_m[i]) begin
            rs_m[i] = 0;
            if (prio_m[i] == 255) mp_m[i] = 1;
            else begin
               wait_offer(i, prio_m[i], req);
               respond(1'b1);
            end
         end
      end
      for (int k = 0; k < 64 && !ev_ready; k++) begin
         if (off_valid) stray = 1;
         @(negedge clk);
      end
      if (off_valid) stray = 1;
      chk(!stray && ev_ready, {req, " scan ends without extra offer"}, int'(stray), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int i = 0; i < NSRC; i++) begin
         pq_m[i] = 0; prio_m[i] = 255; lsi_m[i] = 0; mp_m[i] = 0; rs_m[i] = 0;
      end
      rst_n = 1'b0; ev_valid = 1'b0; ev_kind = 3'd0; ev_src = '0;
      ev_prio = '0; ev_lsi = 1'b0; rsp_valid = 1'b0; rsp_ok = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ev_ready == 1'b1, "R1 ready after reset", int'(ev_ready), 1);
      chk(off_valid == 1'b0, "R1 no offer after reset", int'(off_valid), 0);
      chk(err_count == 4'd0, "R1 err_count after reset", int'(err_count), 0);
      op(0, 0, 0, 0, 1, 0, "R1 R5 trigger on reset-masked entry");

      // R2 R3 R10: sweep every entry through mixed triggers and EOIs
      for (int s = 0; s < NSRC; s++) begin
         op(4, s, (s * 7 + 3) & 8'h7f, 0, 1, 0, "R2 config");
         for (int i = 0; i < 12; i++) begin
            int kind = (((s * 5 + i * 3) % 4) < 2) ? 0 : 1;
            bit ok = ((s + i) % 5) != 0;
            op(kind, s, 0, 0, ok, 0, kind == 0 ? "R2 msi trigger" : "R3 msi eoi");
         end
      end
      rescan("R6 after sweep");
      rescan("R6 empty scan");

      // R4: level source
      op(4, 3, 8'h40, 1, 1, 0, "R4 config level");
      op(5, 3, 0, 0, 1, 0, "R4 level drop");
      op(0, 3, 0, 0, 1, 0, "R4 level trigger");
      op(0, 3, 0, 0, 1, 0, "R4 level retrigger");
      op(1, 3, 0, 0, 1, 0, "R4 level eoi with P");
      op(5, 3, 0, 0, 1, 0, "R4 level drop again");
      op(1, 3, 0, 0, 1, 0, "R4 level eoi without P");

      // R5: masked delivery and unmask
      op(4, 5, 8'hff, 0, 1, 0, "R5 mask");
      op(5, 5, 0, 0, 1, 0, "R5 clear");
      op(0, 5, 0, 0, 1, 0, "R5 trigger while masked");
      op(0, 5, 0, 0, 1, 0, "R5 second trigger while masked");
      op(4, 5, 8'h22, 0, 1, 0, "R5 unmask offers");
      op(4, 5, 8'h23, 0, 1, 0, "R5 reconfig no offer");
      // R5 R6: retry of an entry that became masked
      op(4, 6, 8'h30, 0, 1, 0, "R6 config");
      op(5, 6, 0, 0, 1, 0, "R6 clear");
      op(0, 6, 0, 0, 0, 0, "R6 failed offer");
      op(4, 6, 8'hff, 0, 1, 0, "R5 mask flagged entry");
      rescan("R5 R6 masked retry");
      op(4, 6, 8'h31, 0, 1, 0, "R5 unmask after masked retry");

      // R7: rejection
      op(4, 7, 8'h50, 0, 1, 0, "R7 config");
      op(5, 7, 0, 0, 1, 0, "R7 clear");
      op(0, 7, 0, 0, 1, 0, "R7 trigger");
      op(2, 7, 0, 0, 1, 0, "R7 reject offers");
      op(0, 7, 0, 0, 1, 0, "R7 state kept, trigger queues");
      op(1, 7, 0, 0, 1, 0, "R7 eoi reoffers");
      op(1, 7, 0, 0, 1, 0, "R7 eoi empties");

      // R8: hold while outstanding
      op(4, 8, 8'h10, 0, 1, 0, "R8 config");
      op(5, 8, 0, 0, 1, 0, "R8 clear");
      op(0, 8, 0, 0, 1, 4, "R8 trigger with held events");

      // R9: out of range
      op(0, 20, 0, 0, 1, 0, "R9 trigger out of range");
      op(4, 31, 0, 0, 1, 0, "R9 config out of range");
      for (int k = 0; k < 16; k++) op(1, 16 + k, 0, 0, 1, 0, "R9 saturation");
      op(0, 8, 0, 0, 1, 0, "R9 table intact after bad events");

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule